// File: doc/BRIEF.md
# Byte-Interleaved Tributary Justification Request Handler

This block sits on the add side of a byte-interleaved tributary bus that carries three DS-3 tributaries, one octet per clock. The tributaries take turns in a fixed rotation: tributary 0, then 1, then 2, then 0 again. A frame pulse marks the first octet of each multiframe. From that pulse the block keeps an octet counter, so it knows the owning tributary, the frame, the row and the column of every octet.

A single request line paces the tributaries. The timing master raises it during one octet, and the position of that octet selects both the tributary and the direction of the adjustment. A request during a tributary's H3 octet asks for a negative justification: that H3 octet carries one extra data byte. A request during the first octet of that tributary after the H3 group asks for a positive justification: that octet becomes a stuff byte. Decisions are held for one multiframe and then applied. On the output side the block gives a payload-valid strobe, the owning tributary, the data delayed by one clock, per-tributary event pulses and a conflict pulse.

Geometry: each frame has ROWS rows of COLS columns, and FRAMES frames make a multiframe. Columns below OH = H3_COL + 3 are overhead. The H3 group is columns H3_COL..H3_COL+2 of row H3_ROW in frame 0. The positive-justification window is columns OH..OH+2 of the same row. Default values: ROWS=9, COLS=270, FRAMES=4, H3_ROW=3, H3_COL=6.

Top module: `jreq_handler`

## Requirements
- R1: The octet at counter position p belongs to tributary p mod 3. Position 0 is the octet presented with frame_pulse high. Tributary #1 is encoded as 0. out_trib gives this value one clock after the octet.
- R2: out_data equals the add_data value of the previous clock.
- R3: While locked, a request during tributary t's H3 octet (column H3_COL+t) causes that H3 octet of the next multiframe to have out_valid high and neg_evt[t] pulsing with it.
- R4: While locked, a request during tributary t's window octet (column OH+t of the H3 row, frame 0) causes that octet of the next multiframe to have out_valid low and pos_evt[t] pulsing with it.
- R5: Outside justification octets, out_valid is high exactly when the block is locked and the octet's column is at least OH. It is never high on an overhead column other than an H3 octet under negative justification.
- R6: A justification never acts in the multiframe in which it was requested. It acts only in the next one, and only once.
- R7: If both requests are made for one tributary in one multiframe, the negative one wins and the positive one is dropped. req_conflict pulses one clock after the window octet in which the refused request was made.
- R8: After reset, outputs are low. out_valid stays low and requests are ignored until a second frame pulse arrives exactly one multiframe after the first.
- R9: A frame pulse at any other position drops lock. out_valid stays low until a later pulse arrives at the proper spacing, and all pending and queued justifications are discarded.
- R10: Per tributary, the payload octets per locked multiframe equal FRAMES*ROWS*(COLS-OH)/3. Add one for each negative justification and subtract one for each accepted positive justification requested in the previous multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock, one octet per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Marks the first octet of a multiframe |
| add_data | input | DATA_W | Tributary octet on the add bus |
| just_req | input | 1 | Justification request line, sampled per octet |
| out_data | output | DATA_W | add_data delayed by one clock |
| out_valid | output | 1 | Octet carries payload after justification |
| out_trib | output | TRIB_W | Tributary owning out_data |
| neg_evt | output | NUM_TRIB | Negative justification applied on this octet |
| pos_evt | output | NUM_TRIB | Positive justification (stuff) applied on this octet |
| req_conflict | output | 1 | A positive request was refused in favour of a negative one |

## Verification
The hardest state to reach is a queued justification that is thrown away. The block has to be locked and a request must already be captured, and then a frame pulse has to land off its spacing before the next multiframe boundary. The bench builds this directly: it requests a negative justification and cuts the multiframe short with an early pulse. It then confirms that the next multiframe carries no payload and that the re-locked one has the nominal octet count. Conflicts and simultaneous requests on several tributaries come from table rows and random patterns that set both request windows in one multiframe.

// File: rtl/jreq_pkg.sv
package jreq_pkg;

  typedef enum logic [1:0] {SYNC_NONE, SYNC_ONE, SYNC_LOCK} sync_e;

  // column inside a row
  function automatic int unsigned col_of(input int unsigned pos, input int unsigned cols);
    return pos % cols;
  endfunction

  // row inside a frame
  function automatic int unsigned row_of(input int unsigned pos, input int unsigned cols,
                                         input int unsigned rows);
    return (pos / cols) % rows;
  endfunction

  // frame inside the multiframe
  function automatic int unsigned frame_of(input int unsigned pos, input int unsigned cols,
                                           input int unsigned rows);
    return pos / (cols * rows);
  endfunction

endpackage

// File: rtl/jreq_aligner.sv
module jreq_aligner
  import jreq_pkg::*;
#(
  parameter int unsigned MF_LEN = 9720,
  localparam int unsigned POS_W = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp,
  output logic [POS_W-1:0] cur_pos,
  output logic             aligned,
  output logic             mf_start,
  output logic             slip
);
  sync_e            st_q;
  logic [POS_W-1:0] pos_q;
  logic             expected, lock_now;

  assign expected = (pos_q == POS_W'(MF_LEN - 1));
  assign cur_pos  = (fp || expected) ? '0 : pos_q + 1'b1;
  assign lock_now = fp && expected && (st_q != SYNC_NONE);
  assign slip     = fp && !expected && (st_q != SYNC_NONE);
  assign aligned  = ((st_q == SYNC_LOCK) && !slip) || lock_now;
  assign mf_start = aligned && (cur_pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SYNC_NONE;
      pos_q <= POS_W'(MF_LEN - 1);
    end else begin
      pos_q <= cur_pos;
      if (lock_now)                          st_q <= SYNC_LOCK;
      else if (slip)                         st_q <= SYNC_ONE;
      else if (fp && st_q == SYNC_NONE)      st_q <= SYNC_ONE;
    end
  end

  // R8: lock is only entered on a frame pulse
  a_r8_lock_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SYNC_LOCK && $past(st_q) != SYNC_LOCK) |-> $past(fp));

  // R9: a misplaced pulse leaves the block unlocked
  a_r9_slip_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> (st_q != SYNC_LOCK));

endmodule

// File: rtl/jreq_slot.sv
module jreq_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic req,
  input  logic at_h3,
  input  logic at_pwin,
  input  logic mf_start,
  input  logic flush,
  output logic use_neg,
  output logic use_pos,
  output logic conflict
);
  logic cap_neg, cap_pos;

  assign conflict = capture && req && at_pwin && cap_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_neg <= 1'b0; cap_pos <= 1'b0;
      use_neg <= 1'b0; use_pos <= 1'b0;
    end else if (flush) begin
      cap_neg <= 1'b0; cap_pos <= 1'b0;
      use_neg <= 1'b0; use_pos <= 1'b0;
    end else if (mf_start) begin
      use_neg <= cap_neg; use_pos <= cap_pos;
      cap_neg <= 1'b0;    cap_pos <= 1'b0;
    end else if (capture && req) begin
      if (at_h3)                  cap_neg <= 1'b1;
      else if (at_pwin && !cap_neg) cap_pos <= 1'b1;
    end
  end

  // R7: never both directions queued for one multiframe
  a_r7_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(use_neg && use_pos) && !(cap_neg && cap_pos));

  // R9: a slip discards everything pending
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(cap_neg || cap_pos || use_neg || use_pos));

endmodule

// File: rtl/jreq_handler.sv
module jreq_handler
  import jreq_pkg::*;
#(
  parameter int unsigned NUM_TRIB = 3,
  parameter int unsigned ROWS     = 9,
  parameter int unsigned COLS     = 270,
  parameter int unsigned FRAMES   = 4,
  parameter int unsigned H3_ROW   = 3,
  parameter int unsigned H3_COL   = 6,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned TRIB_W  = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1,
  localparam int unsigned OH_COLS = H3_COL + NUM_TRIB,
  localparam int unsigned MF_LEN  = FRAMES * ROWS * COLS,
  localparam int unsigned POS_W   = $clog2(MF_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  input  logic [DATA_W-1:0] add_data,
  input  logic              just_req,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic [TRIB_W-1:0] out_trib,
  output logic [NUM_TRIB-1:0] neg_evt,
  output logic [NUM_TRIB-1:0] pos_evt,
  output logic              req_conflict
);
  logic [POS_W-1:0]    cur_pos;
  logic                aligned, mf_start, slip;
  int unsigned         p_i, col_i, row_i, frm_i;
  logic                in_jrow, at_h3, at_pwin, payload;
  logic [TRIB_W-1:0]   cur_trib;
  logic [NUM_TRIB-1:0] use_neg, use_pos, slot_conf, neg_hit, stuff_hit;
  logic                valid_c;

  jreq_aligner #(.MF_LEN(MF_LEN)) u_align (
    .clk(clk), .rst_n(rst_n), .fp(frame_pulse),
    .cur_pos(cur_pos), .aligned(aligned), .mf_start(mf_start), .slip(slip)
  );

  // octet position decode
  assign p_i      = 32'(cur_pos);
  assign col_i    = col_of(p_i, COLS);
  assign row_i    = row_of(p_i, COLS, ROWS);
  assign frm_i    = frame_of(p_i, COLS, ROWS);
  assign cur_trib = TRIB_W'(col_i % NUM_TRIB);
  assign in_jrow  = (frm_i == 0) && (row_i == H3_ROW);
  assign at_h3    = in_jrow && (col_i >= H3_COL) && (col_i < OH_COLS);
  assign at_pwin  = in_jrow && (col_i >= OH_COLS) && (col_i < OH_COLS + NUM_TRIB);
  assign payload  = (col_i >= OH_COLS);

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_slot
    logic mine;
    assign mine = (cur_trib == TRIB_W'(t));
    jreq_slot u_slot (
      .clk(clk), .rst_n(rst_n), .capture(aligned), .req(just_req),
      .at_h3(at_h3 && mine), .at_pwin(at_pwin && mine),
      .mf_start(mf_start), .flush(slip),
      .use_neg(use_neg[t]), .use_pos(use_pos[t]), .conflict(slot_conf[t])
    );
    assign neg_hit[t]   = aligned && at_h3 && mine && use_neg[t];
    assign stuff_hit[t] = aligned && at_pwin && mine && use_pos[t];
  end

  assign valid_c = aligned && ((payload && !(|stuff_hit)) || (|neg_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data     <= '0;
      out_valid    <= 1'b0;
      out_trib     <= '0;
      neg_evt      <= '0;
      pos_evt      <= '0;
      req_conflict <= 1'b0;
    end else begin
      out_data     <= add_data;
      out_valid    <= valid_c;
      out_trib     <= cur_trib;
      neg_evt      <= neg_hit;
      pos_evt      <= stuff_hit;
      req_conflict <= |slot_conf;
    end
  end

  // R3: a negative event carries data
  a_r3_neg_carries_data: assert property (@(posedge clk) disable iff (!rst_n)
    (|neg_evt) |-> out_valid);

  // R4: a positive event is a stuff octet
  a_r4_pos_is_stuff: assert property (@(posedge clk) disable iff (!rst_n)
    (|pos_evt) |-> !out_valid);

  // R6: at most one justification event per octet
  a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({neg_evt, pos_evt}));

  // R7: a conflict is only reported after a request
  a_r7_conflict_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_conflict |-> $past(just_req));

endmodule

// File: tb/tb_jreq_handler.sv
module tb_jreq_handler;
  localparam int CLK_P  = 10;
  localparam int NT     = 3;
  localparam int ROWS   = 4;
  localparam int COLS   = 15;
  localparam int FRAMES = 4;
  localparam int H3R    = 3;
  localparam int H3C    = 6;
  localparam int OH     = H3C + NT;
  localparam int FL     = ROWS * COLS;
  localparam int MF     = FRAMES * FL;
  localparam int NOM    = FRAMES * ROWS * (COLS - OH) / NT;
  localparam int NPAT   = 15;
  // {neg[2:0], pos[2:0]} per multiframe
  localparam logic [5:0] TABLE [9] = '{6'b111_000, 6'b001_010, 6'b000_000, 6'b100_001,
                                       6'b011_011, 6'b000_100, 6'b111_000, 6'b000_111,
                                       6'b110_101};

  logic clk = 0, rst_n = 0, frame_pulse = 0, just_req = 0;
  logic [7:0] add_data = 0, out_data;
  logic out_valid, req_conflict;
  logic [1:0] out_trib;
  logic [NT-1:0] neg_evt, pos_evt;

  int n_chk = 0, n_fail = 0;
  int err_data = 0, err_trib = 0, err_oh = 0;
  int bpos = MF - 1;
  bit have_prev = 0;
  logic [7:0] prev_data;
  int acc_cnt[NT], acc_neg[NT], acc_pos[NT], acc_conf;
  int last_cnt[NT], last_neg[NT], last_pos[NT], last_conf;
  logic [5:0] pats[NPAT];

  always #(CLK_P/2) clk = ~clk;

  jreq_handler #(.NUM_TRIB(NT), .ROWS(ROWS), .COLS(COLS), .FRAMES(FRAMES),
                 .H3_ROW(H3R), .H3_COL(H3C), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .add_data(add_data),
    .just_req(just_req), .out_data(out_data), .out_valid(out_valid),
    .out_trib(out_trib), .neg_evt(neg_evt), .pos_evt(pos_evt),
    .req_conflict(req_conflict)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic req_at(input int p, input logic [2:0] ng, input logic [2:0] ps);
    int f, r, c;
    f = p / FL; r = (p % FL) / COLS; c = p % COLS;
    if (f == 0 && r == H3R) begin
      if (c >= H3C && c < OH)     return ng[c - H3C];
      if (c >= OH && c < OH + NT) return ps[c - OH];
    end
    return 1'b0;
  endfunction

  task automatic step(input logic fp, input logic [2:0] ng, input logic [2:0] ps);
    int f, r, c, t;
    @(negedge clk);
    if (have_prev) begin
      if (bpos == 0) begin
        for (int k = 0; k < NT; k++) begin
          last_cnt[k] = acc_cnt[k]; last_neg[k] = acc_neg[k]; last_pos[k] = acc_pos[k];
          acc_cnt[k] = 0; acc_neg[k] = 0; acc_pos[k] = 0;
        end
        last_conf = acc_conf; acc_conf = 0;
      end
      f = bpos / FL; r = (bpos % FL) / COLS; c = bpos % COLS; t = bpos % NT;
      if (out_data !== prev_data) err_data++;
      if (int'(out_trib) != t) err_trib++;
      if (out_valid && c < OH && !(f == 0 && r == H3R && c >= H3C)) err_oh++;
      if (out_valid) acc_cnt[t]++;
      for (int k = 0; k < NT; k++) begin
        if (neg_evt[k]) acc_neg[k]++;
        if (pos_evt[k]) acc_pos[k]++;
      end
      if (req_conflict) acc_conf++;
    end
    bpos = fp ? 0 : (bpos + 1) % MF;
    frame_pulse = fp;
    just_req = req_at(bpos, ng, ps);
    add_data = 8'($urandom);
    prev_data = add_data;
    have_prev = 1;
  endtask

  task automatic run(input int n, input logic fp0, input logic [2:0] ng, input logic [2:0] ps);
    for (int k = 0; k < n; k++) step(fp0 && k == 0, ng, ps);
  endtask

  task automatic check_mf(input int j);
    int ecnt, eneg, epos, econf;
    logic n, p;
    for (int t = 0; t < NT; t++) begin
      if (j < 2) begin
        ecnt = (j == 0) ? 0 : NOM; eneg = 0; epos = 0;
      end else begin
        n = pats[j-1][3+t]; p = pats[j-1][t];
        eneg = int'(n); epos = int'(p && !n);
        ecnt = NOM + eneg - epos;
      end
      check(last_cnt[t] == ecnt, (j < 2) ? "R8 payload count" : "R6/R10 payload count",
            last_cnt[t], ecnt);
      check(last_neg[t] == eneg, "R3 negative events", last_neg[t], eneg);
      check(last_pos[t] == epos, "R4 R7 positive events", last_pos[t], epos);
    end
    econf = (j == 0) ? 0 : $countones(pats[j][5:3] & pats[j][2:0]);
    check(last_conf == econf, "R7 conflicts", last_conf, econf);
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < NT; k++) begin
      acc_cnt[k] = 0; acc_neg[k] = 0; acc_pos[k] = 0;
      last_cnt[k] = 0; last_neg[k] = 0; last_pos[k] = 0;
    end
    acc_conf = 0; last_conf = 0;
    for (int i = 0; i < NPAT; i++) pats[i] = (i < 9) ? TABLE[i] : 6'($urandom);

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R8: reset state
    check(!out_valid, "R8 reset valid", int'(out_valid), 0);
    check(neg_evt == 0 && pos_evt == 0, "R8 reset events", int'({neg_evt, pos_evt}), 0);
    check(!req_conflict, "R8 reset conflict", int'(req_conflict), 0);

    // table plus random patterns, one multiframe per entry
    for (int i = 0; i < NPAT; i++) begin
      run(MF, 1'b1, pats[i][5:3], pats[i][2:0]);
      if (i >= 1) check_mf(i - 1);
    end

    // R9: capture a negative request for trib 2, then slip before it applies
    run(70, 1'b1, 3'b100, 3'b000);
    run(MF, 1'b1, 3'b000, 3'b000);          // pulse off its spacing
    run(MF, 1'b1, 3'b000, 3'b000);          // relock pulse; closes slipped MF
    for (int t = 0; t < NT; t++)
      check(last_cnt[t] == 0, "R9 no payload after slip", last_cnt[t], 0);
    run(MF, 1'b1, 3'b000, 3'b000);          // closes relocked MF
    for (int t = 0; t < NT; t++) begin
      check(last_cnt[t] == NOM, "R9 relocked count", last_cnt[t], NOM);
      check(last_neg[t] == 0, "R9 discarded request", last_neg[t], 0);
    end

    check(err_trib == 0, "R1 tributary order mismatches", err_trib, 0);
    check(err_data == 0, "R2 data delay mismatches", err_data, 0);
    check(err_oh == 0, "R5 valid on overhead", err_oh, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule